// File: doc/BRIEF.md
# Register Rename Map Table

This block holds the architectural-to-physical register mapping of an out-of-order core. All architectural registers share one index space. Integer registers come first, floating-point registers follow them, and every index above the floating-point range is a miscellaneous register. Miscellaneous registers are never renamed. Each of the two renamable classes has its own physical range. Each class also has its own internal free pool, which works as a FIFO of unused physical indices.

A rename request uses a valid/ready handshake. In the same cycle it returns the old mapping and a freshly allocated physical register, and the table takes the new mapping at the clock edge. Other ports give a side-effect-free lookup, a direct set-entry write for recovery, and a release input that returns a freed physical register to the pool of its class. The block also reports how many renames can still proceed, which is the smaller of the two pool occupancies.

With the default parameters there are 8 integer and 8 float architectural registers. There are 16 physical registers of each class and 4 miscellaneous registers. The integer zero register is architectural index 0. The float zero register is index 8, and its exemption is enabled.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, integer architectural index i maps to physical i. Float index NLI+j maps to physical NPI+j, so with the defaults index 10 maps to 18. free_count reads 8.
- R2: A handshake on an integer register other than the zero register returns rn_prev equal to the current mapping. It also returns rn_new taken from the integer pool in FIFO order; after reset that order is 8, 9, 10, and so on. From the next cycle the lookup of that register returns rn_new.
- R3: A handshake on a float register other than the float zero register returns rn_new from the float pool. That value lies in [NPI, NPI+NPF); the first one after reset is NPI+NLF = 24.
- R4: A rename of integer index 0 allocates nothing and returns rn_new = rn_prev = 0. The table and free_count are unchanged.
- R5: With the float-zero exemption enabled, a rename of float index 8 allocates nothing and returns rn_new = rn_prev = 16.
- R6: A miscellaneous index a (a ≥ 16) maps to physical (a − 16) + 32 for both rename and lookup. A rename of it returns rn_new = rn_prev, allocates nothing and changes nothing.
- R7: A lookup made in the same cycle as a rename of the same register returns the mapping from before the rename.
- R8: set_valid overwrites the mapping of an integer or float register. If a set-entry and a rename hit the same register in one cycle, the set-entry value wins. A set-entry aimed at a miscellaneous index is ignored.
- R9: free_count equals the minimum of the integer and float pool occupancies, updated one cycle after each allocation or release.
- R10: A release of a physical index below NPI+NPF returns it to the tail of its class pool. A release of an index outside that range, or of a zero register's binding (physical 0 or 16), is ignored.
- R11: rn_ready is low when the register named by rn_arch needs an allocation and its class pool is empty. rn_ready stays high for zero-register and miscellaneous requests. A request without ready changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request valid |
| rn_ready | output | 1 | Rename can be accepted |
| rn_arch | input | AW (5) | Architectural index to rename |
| rn_new | output | PW (6) | New physical mapping |
| rn_prev | output | PW (6) | Previous physical mapping |
| lk_arch | input | AW (5) | Architectural index to look up |
| lk_phys | output | PW (6) | Current mapping of lk_arch |
| set_valid | input | 1 | Set-entry write enable |
| set_arch | input | AW (5) | Architectural index to overwrite |
| set_phys | input | PW (6) | Physical index to write |
| rel_valid | input | 1 | Release strobe |
| rel_phys | input | PW (6) | Physical index being freed |
| free_count | output | CW (5) | Renames that can still proceed |

## Verification
Assertions check on every cycle that each allocated register falls inside its class range. They also check that zero-register and miscellaneous renames return equal new and previous mappings, and that free_count equals the smaller pool count. In addition, they confirm that table writes land on the following cycle with set-entry taking priority, and that pool counts move by exactly one per pop. The FIFO order of allocation, the reset bindings, and the fact that releases of zero-register or out-of-range indices are ignored can only be shown by the bench's scenarios. The same holds for pre-rename lookup forwarding and for ready dropping only when the integer pool is drained.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_MISC = 2'd2
    } rn_class_e;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int DEPTH      = 16,
    parameter int IDXW       = 6,
    parameter int INIT_CNT   = 8,
    parameter int INIT_FIRST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push,
    input  logic [IDXW-1:0] push_idx,
    output logic [IDXW-1:0] head,
    output logic            empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][IDXW-1:0] slots;
        logic [PTRW-1:0]            rd;
        logic [PTRW-1:0]            wr;
        logic [CNTW-1:0]            cnt;
    } pool_st_t;

    pool_st_t st_d, st_q;
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNTW'(DEPTH)) || do_pop);
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTRW'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
        end
        if (do_push) begin
            st_d.slots[st_q.wr] = push_idx;
            st_d.wr = (st_q.wr == PTRW'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                st_q.slots[k] <= (k < INIT_CNT) ? IDXW'(INIT_FIRST + k) : '0;
            end
            st_q.rd  <= '0;
            st_q.wr  <= PTRW'(INIT_CNT % DEPTH);
            st_q.cnt <= CNTW'(INIT_CNT);
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.slots[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;

    // R10: no release may arrive at a full pool without a pop
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && (count == CNTW'(DEPTH))));

    // R9: occupancy moves by exactly one on a lone pop
    p_pop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NMAP = 16,
    parameter int NLI  = 8,
    parameter int NPI  = 16,
    parameter int PW   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NMAP)-1:0] rd_a_idx,
    output logic [PW-1:0]           rd_a_data,
    input  logic [$clog2(NMAP)-1:0] rd_b_idx,
    output logic [PW-1:0]           rd_b_data,
    input  logic                    wr_a_en,
    input  logic [$clog2(NMAP)-1:0] wr_a_idx,
    input  logic [PW-1:0]           wr_a_data,
    input  logic                    wr_b_en,
    input  logic [$clog2(NMAP)-1:0] wr_b_idx,
    input  logic [PW-1:0]           wr_b_data
);
    localparam int MW = $clog2(NMAP);

    typedef struct packed {
        logic [NMAP-1:0][PW-1:0] ent;
    } map_st_t;

    map_st_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (wr_a_en) map_d.ent[wr_a_idx] = wr_a_data;
        // recovery write is applied last so it takes priority
        if (wr_b_en) map_d.ent[wr_b_idx] = wr_b_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NMAP; i++) begin
                map_q.ent[i] <= (i < NLI) ? PW'(i) : PW'(NPI + i - NLI);
            end
        end else begin
            map_q <= map_d;
        end
    end

    assign rd_a_data = map_q.ent[rd_a_idx];
    assign rd_b_data = map_q.ent[rd_b_idx];

    // R8: a set-entry lands on the next cycle
    p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b_en |=> (map_q.ent[$past(wr_b_idx)] == $past(wr_b_data)));

    // R2: a rename write lands unless overridden by a set-entry
    p_rename_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_en && !(wr_b_en && (wr_b_idx == wr_a_idx)))
        |=> (map_q.ent[$past(wr_a_idx)] == $past(wr_a_data)));

    initial begin
        p_size_ok: assert (MW >= 1);
    end
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map #(
    parameter int NLI        = 8,
    parameter int NLF        = 8,
    parameter int NPI        = 16,
    parameter int NPF        = 16,
    parameter int NMISC      = 4,
    parameter int INT_ZERO   = 0,
    parameter int FP_ZERO    = 8,
    parameter bit FP_ZERO_EN = 1'b1,
    localparam int NLOG      = NLI + NLF,
    localparam int NPHY      = NPI + NPF,
    localparam int AW        = $clog2(NLOG + NMISC),
    localparam int PW        = $clog2(NPHY + NMISC),
    localparam int CW        = $clog2(((NPI > NPF) ? NPI : NPF) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rn_valid,
    output logic          rn_ready,
    input  logic [AW-1:0] rn_arch,
    output logic [PW-1:0] rn_new,
    output logic [PW-1:0] rn_prev,
    input  logic [AW-1:0] lk_arch,
    output logic [PW-1:0] lk_phys,
    input  logic          set_valid,
    input  logic [AW-1:0] set_arch,
    input  logic [PW-1:0] set_phys,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic [CW-1:0] free_count
);
    import rn_pkg::*;

    localparam int MW          = $clog2(NLOG);
    localparam int ICW         = $clog2(NPI + 1);
    localparam int FCW         = $clog2(NPF + 1);
    localparam int FP_ZERO_PHY = NPI + FP_ZERO - NLI;

    function automatic rn_class_e classify(input logic [AW-1:0] a);
        if (a < AW'(NLI))       return CLS_INT;
        else if (a < AW'(NLOG)) return CLS_FP;
        else                    return CLS_MISC;
    endfunction

    function automatic logic [PW-1:0] misc_phys(input logic [AW-1:0] a);
        return PW'(a) - PW'(NLOG) + PW'(NPHY);
    endfunction

    rn_class_e rn_cls, lk_cls, set_cls;
    logic      rn_is_zero, needs_alloc, fire, fire_int, fire_fp;
    logic      rel_int, rel_fp;
    logic [PW-1:0] tbl_rn, tbl_lk, int_head, fp_head;
    logic      int_empty, fp_empty;
    logic [ICW-1:0] int_cnt;
    logic [FCW-1:0] fp_cnt;

    always_comb begin
        rn_cls      = classify(rn_arch);
        lk_cls      = classify(lk_arch);
        set_cls     = classify(set_arch);
        rn_is_zero  = ((rn_cls == CLS_INT) && (rn_arch == AW'(INT_ZERO))) ||
                      (FP_ZERO_EN && (rn_cls == CLS_FP) && (rn_arch == AW'(FP_ZERO)));
        needs_alloc = (rn_cls != CLS_MISC) && !rn_is_zero;
        rn_ready    = !needs_alloc ||
                      ((rn_cls == CLS_INT) ? !int_empty : !fp_empty);
        fire        = rn_valid && rn_ready && needs_alloc;
        fire_int    = fire && (rn_cls == CLS_INT);
        fire_fp     = fire && (rn_cls == CLS_FP);
        rn_prev     = (rn_cls == CLS_MISC) ? misc_phys(rn_arch) : tbl_rn;
        if (!needs_alloc)           rn_new = rn_prev;
        else if (rn_cls == CLS_INT) rn_new = int_head;
        else                        rn_new = fp_head;
        lk_phys     = (lk_cls == CLS_MISC) ? misc_phys(lk_arch) : tbl_lk;
        rel_int     = rel_valid && (rel_phys < PW'(NPI)) &&
                      (rel_phys != PW'(INT_ZERO));
        rel_fp      = rel_valid && (rel_phys >= PW'(NPI)) && (rel_phys < PW'(NPHY)) &&
                      !(FP_ZERO_EN && (rel_phys == PW'(FP_ZERO_PHY)));
        free_count  = (CW'(int_cnt) < CW'(fp_cnt)) ? CW'(int_cnt) : CW'(fp_cnt);
    end

    rn_map_table #(
        .NMAP(NLOG), .NLI(NLI), .NPI(NPI), .PW(PW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (MW'(rn_arch)),
        .rd_a_data (tbl_rn),
        .rd_b_idx  (MW'(lk_arch)),
        .rd_b_data (tbl_lk),
        .wr_a_en   (fire),
        .wr_a_idx  (MW'(rn_arch)),
        .wr_a_data (rn_new),
        .wr_b_en   (set_valid && (set_cls != CLS_MISC)),
        .wr_b_idx  (MW'(set_arch)),
        .wr_b_data (set_phys)
    );

    rn_free_pool #(
        .DEPTH(NPI), .IDXW(PW), .INIT_CNT(NPI - NLI), .INIT_FIRST(NLI)
    ) u_int_pool (
        .clk(clk), .rst_n(rst_n),
        .pop(fire_int), .push(rel_int), .push_idx(rel_phys),
        .head(int_head), .empty(int_empty), .count(int_cnt)
    );

    rn_free_pool #(
        .DEPTH(NPF), .IDXW(PW), .INIT_CNT(NPF - NLF), .INIT_FIRST(NPI + NLF)
    ) u_fp_pool (
        .clk(clk), .rst_n(rst_n),
        .pop(fire_fp), .push(rel_fp), .push_idx(rel_phys),
        .head(fp_head), .empty(fp_empty), .count(fp_cnt)
    );

    // R2: integer allocations stay in the integer physical range
    p_int_in_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_int |-> (int_head < PW'(NPI)));

    // R3: float allocations stay in the float physical range
    p_fp_in_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_fp |-> ((fp_head >= PW'(NPI)) && (fp_head < PW'(NPHY))));

    // R4: integer zero register is always accepted and maps to itself
    p_zero_noalloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && (rn_arch == AW'(INT_ZERO))) |-> (rn_ready && (rn_new == rn_prev)));

    // R6: misc registers bypass the table beyond the physical range
    p_misc_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && (rn_arch >= AW'(NLOG))) |->
        (rn_ready && (rn_new == rn_prev) && (rn_new >= PW'(NPHY))));

    // R9: free count is the smaller pool occupancy
    p_free_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(int_cnt) >= free_count) && (CW'(fp_cnt) >= free_count) &&
        ((CW'(int_cnt) == free_count) || (CW'(fp_cnt) == free_count)));

    // R11: an allocation never happens from an empty pool
    p_ready_pool_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_int |-> !int_empty) and (fire_fp |-> !fp_empty));
endmodule

// File: tb/rn_rename_map_tb.sv
module rn_rename_map_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rn_valid = 1'b0, set_valid = 1'b0, rel_valid = 1'b0;
    logic [4:0] rn_arch = '0, lk_arch = '0, set_arch = '0;
    logic [5:0] set_phys = '0, rel_phys = '0;
    logic       rn_ready;
    logic [5:0] rn_new, rn_prev, lk_phys;
    logic [4:0] free_count;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rn_rename_map u_dut (
        .clk(clk), .rst_n(rst_n),
        .rn_valid(rn_valid), .rn_ready(rn_ready), .rn_arch(rn_arch),
        .rn_new(rn_new), .rn_prev(rn_prev),
        .lk_arch(lk_arch), .lk_phys(lk_phys),
        .set_valid(set_valid), .set_arch(set_arch), .set_phys(set_phys),
        .rel_valid(rel_valid), .rel_phys(rel_phys),
        .free_count(free_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic look(input int a, input int exp, input string req);
        @(negedge clk);
        lk_arch = 5'(a);
        #1 chk(req, int'(lk_phys), exp);
    endtask

    // one rename handshake with same-cycle checks, then commit
    task automatic ren(input int a, input int exp_new, input int exp_prev, input string req);
        @(negedge clk);
        rn_valid = 1'b1;
        rn_arch  = 5'(a);
        #1;
        chk({req, " ready"}, int'(rn_ready), 1);
        chk({req, " new"}, int'(rn_new), exp_new);
        chk({req, " prev"}, int'(rn_prev), exp_prev);
        @(posedge clk);
        #1 rn_valid = 1'b0;
    endtask

    task automatic rel(input int p);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_phys  = 6'(p);
        @(posedge clk);
        #1 rel_valid = 1'b0;
    endtask

    task automatic fc(input int exp, input string req);
        @(negedge clk);
        #1 chk(req, int'(free_count), exp);
    endtask

    task automatic t_reset;
        fc(8, "R1 free_count");
        look(3, 3, "R1 int");
        look(10, 18, "R1 fp");
        look(17, 33, "R6 misc lookup");
    endtask

    task automatic t_rename_int;
        @(negedge clk);
        rn_valid = 1'b1; rn_arch = 5'd3; lk_arch = 5'd3;
        #1;
        chk("R2 new", int'(rn_new), 8);
        chk("R2 prev", int'(rn_prev), 3);
        chk("R7 same-cycle lookup", int'(lk_phys), 3);
        @(posedge clk);
        #1 rn_valid = 1'b0;
        look(3, 8, "R2 table");
        fc(7, "R9 after int alloc");
        ren(3, 9, 8, "R2 second");
        fc(6, "R9 min");
    endtask

    task automatic t_rename_fp;
        ren(12, 24, 20, "R3");
        look(12, 24, "R3 table");
        fc(6, "R9 int smaller");
    endtask

    task automatic t_zero_misc;
        ren(0, 0, 0, "R4");
        look(0, 0, "R4 table");
        fc(6, "R4 no alloc");
        ren(8, 16, 16, "R5");
        look(8, 16, "R5 table");
        ren(18, 34, 34, "R6");
        look(18, 34, "R6 lookup");
        fc(6, "R6 no alloc");
    endtask

    task automatic t_set;
        @(negedge clk);
        set_valid = 1'b1; set_arch = 5'd5; set_phys = 6'd13;
        @(posedge clk);
        #1 set_valid = 1'b0;
        look(5, 13, "R8 overwrite");
        @(negedge clk);
        set_valid = 1'b1; set_arch = 5'd19; set_phys = 6'd5;
        @(posedge clk);
        #1 set_valid = 1'b0;
        look(19, 35, "R8 misc ignored");
        @(negedge clk);
        rn_valid = 1'b1; rn_arch = 5'd6;
        set_valid = 1'b1; set_arch = 5'd6; set_phys = 6'd14;
        #1 chk("R8 concurrent rename new", int'(rn_new), 10);
        @(posedge clk);
        #1 begin rn_valid = 1'b0; set_valid = 1'b0; end
        look(6, 14, "R8 set wins");
        fc(5, "R9 after concurrent");
    endtask

    task automatic t_release;
        rel(3);
        fc(6, "R10 int release");
        rel(40);
        fc(6, "R10 out of range ignored");
        rel(0);
        fc(6, "R10 int zero ignored");
        rel(16);
        fc(6, "R10 fp zero ignored");
    endtask

    task automatic t_drain;
        int exp_seq[6] = '{11, 12, 13, 14, 15, 3};
        int prev = 1;
        for (int k = 0; k < 6; k++) begin
            ren(1, exp_seq[k], prev, "R10 FIFO order");
            prev = exp_seq[k];
        end
        fc(0, "R9 drained");
        @(negedge clk);
        rn_valid = 1'b1; rn_arch = 5'd2;
        #1 chk("R11 ready low", int'(rn_ready), 0);
        @(posedge clk);
        #1 rn_valid = 1'b0;
        look(2, 2, "R11 no change while stalled");
        look(1, 3, "R11 last mapping");
        @(negedge clk);
        rn_arch = 5'd0;
        #1 chk("R11 zero ready", int'(rn_ready), 1);
        rn_arch = 5'd18;
        #1 chk("R11 misc ready", int'(rn_ready), 1);
        rn_arch = 5'd12;
        #1 chk("R11 fp ready", int'(rn_ready), 1);
        rel(11);
        fc(1, "R9 after refill");
        ren(2, 11, 2, "R11 ready again");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rename_int();
        t_rename_fp();
        t_zero_misc();
        t_set();
        t_release();
        t_drain();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule